// File: doc/BRIEF.md
# Watchdog Key Sequence Checker

This block sits on the bus side of a watchdog timer. It watches writes to a 16-bit service register and decides whether a two-word key sequence arrived correctly and in time. The same logic serves both the periodic service (refresh) sequence and the unlock sequence. A static select input chooses which key pair applies.

A key word can be written as one full 16-bit access or as two byte accesses. In a byte pair the high byte comes first and the low byte second. The checker judges a word only once all of it is present. A lone leading byte never raises an error, even when its value is wrong. The second word must be complete no more than 20 bus clocks after the first word completed.

A correct sequence gives a one-cycle success pulse. A wrong word, a wrong lane order or a late (or missing) second word gives a one-cycle error pulse. After either pulse the checker returns to waiting for a fresh first word. While the block input is high, every write is ignored. This input covers the short interval between the configuration window closing and the timer reload.

Top module: `wdk_seq_check`

## Requirements
- R1: After reset both `ok_pulse` and `err_pulse` are low, and the checker waits for a first key word.
- R2: A 16-bit write (`byte_en`=2'b11) of key 1, followed by a 16-bit write of key 2, raises `ok_pulse` in the cycle after the key 2 write is sampled. With `unlock_sel`=0 the keys are 16'hA602 and 16'hB480.
- R3: A byte pair forms one word: `byte_en`=2'b10 carries the high byte in `wr_data[15:8]`, then `byte_en`=2'b01 carries the low byte in `wr_data[7:0]`. The leading high byte never causes `err_pulse`, whatever its value.
- R4: Byte-pair words and 16-bit words may be mixed freely within one sequence.
- R5: The gap is counted in bus clocks from the write that completes key 1 to the write that completes key 2. A gap of 20 passes. A gap of 21 gives `err_pulse` and no `ok_pulse`.
- R6: If key 1 completed and no further word completes, `err_pulse` rises exactly 21 cycles after the key 1 write was sampled.
- R7: A completed word that differs from the expected key raises `err_pulse` one cycle after it is sampled, and the checker returns to waiting for key 1.
- R8: A low byte with no pending high byte, a second high byte while one is pending, or a 16-bit write while a high byte is pending raises `err_pulse` and discards the pending byte.
- R9: Writes sampled while `blocked` is high have no effect on the sequence and cause no pulse.
- R10: With `unlock_sel`=1 the key pair is 16'h5A3C then 16'h96E1, and the refresh keys are treated as wrong values.
- R11: Each pulse lasts one cycle, the two pulses are never high together, and after either pulse a new sequence must start again from key 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the service register |
| byte_en | input | 2 | Lane enables: bit 1 is the high byte, bit 0 is the low byte |
| wr_data | input | 16 | Write data |
| blocked | input | 1 | When high, writes are ignored |
| unlock_sel | input | 1 | Static select: 0 uses the refresh keys, 1 uses the unlock keys |
| ok_pulse | output | 1 | One-cycle pulse when a sequence succeeds |
| err_pulse | output | 1 | One-cycle pulse on a wrong value, wrong order or timeout |

## Verification
The key sequence is driven in several ways: as full words, as byte pairs, and as mixed forms in both orders. Passing in every form shows that assembly and matching do not depend on access width. Gaps of 20 and 21 cycles, plus a silent wait, separate a deadline measured from completion to completion from one that is off by one or measured from the first byte. Wrong low bytes, wrong leading bytes and misordered lanes show whether checking happens only on complete words. Blocked writes, the unlock key set and a repeated key 2 after success confirm that ignored input, key selection and the return to idle are visible at the pulses.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } wdk_state_e;

  localparam logic [1:0] LANE_FULL = 2'b11;
  localparam logic [1:0] LANE_HI   = 2'b10;
  localparam logic [1:0] LANE_LO   = 2'b01;
endpackage

// File: rtl/wdk_assemble.sv
module wdk_assemble
  import wdk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        byte_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              blocked,
  input  logic              flush,
  output logic              word_vld,
  output logic [DATA_W-1:0] word,
  output logic              order_err,
  output logic              pend
);
  localparam int HALF_W = DATA_W / 2;

  logic              pend_q;
  logic [HALF_W-1:0] hi_q;
  logic              set_hi;
  logic              acc;

  assign acc  = wr_en && !blocked;
  assign pend = pend_q;

  always_comb begin
    word_vld  = 1'b0;
    order_err = 1'b0;
    set_hi    = 1'b0;
    word      = wr_data;
    if (acc) begin
      case (byte_en)
        LANE_FULL: begin
          if (pend_q) order_err = 1'b1;
          else        word_vld  = 1'b1;
        end
        LANE_HI: begin
          if (pend_q) order_err = 1'b1;
          else        set_hi    = 1'b1;
        end
        LANE_LO: begin
          if (pend_q) begin
            word_vld = 1'b1;
            word     = {hi_q, wr_data[HALF_W-1:0]};
          end else begin
            order_err = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush || order_err || word_vld) pend_q <= 1'b0;
    else if (set_hi)                           pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (set_hi) hi_q <= wr_data[DATA_W-1:HALF_W];
  end

  // R3: a pending half word is never held across a completed word
  p_pend_cleared_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && word_vld) |=> !pend_q);
endmodule

// File: rtl/wdk_gap_timer.sv
module wdk_gap_timer #(
  parameter int GAP_MAX = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(GAP_MAX + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_MAX);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start)                cnt_q <= '0;
    else if (run && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && !start && (cnt_q == LIMIT);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
endmodule

// File: rtl/wdk_judge.sv
module wdk_judge
  import wdk_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] REF_KEY1 = 16'hA602,
  parameter logic [DATA_W-1:0] REF_KEY2 = 16'hB480,
  parameter logic [DATA_W-1:0] UNL_KEY1 = 16'h5A3C,
  parameter logic [DATA_W-1:0] UNL_KEY2 = 16'h96E1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              unlock_sel,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word,
  input  logic              order_err,
  input  logic              expired,
  output logic              start,
  output logic              armed,
  output logic              ok_pulse,
  output logic              err_pulse
);
  wdk_state_e        state_q, state_n;
  logic              ok_n, err_n;
  logic [DATA_W-1:0] key1, key2;

  assign key1  = unlock_sel ? UNL_KEY1 : REF_KEY1;
  assign key2  = unlock_sel ? UNL_KEY2 : REF_KEY2;
  assign armed = (state_q == ST_ARMED);

  always_comb begin
    state_n = state_q;
    ok_n    = 1'b0;
    err_n   = 1'b0;
    start   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (order_err) begin
          err_n = 1'b1;
        end else if (word_vld) begin
          if (word == key1) begin
            state_n = ST_ARMED;
            start   = 1'b1;
          end else begin
            err_n = 1'b1;
          end
        end
      end
      ST_ARMED: begin
        if (expired || order_err) begin
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end else if (word_vld) begin
          if (word == key2) ok_n  = 1'b1;
          else              err_n = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ok_pulse  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      state_q   <= state_n;
      ok_pulse  <= ok_n;
      err_pulse <= err_n;
    end
  end

  p_pulse_to_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (ok_pulse || err_pulse) |-> (state_q == ST_IDLE));
  p_ok_from_armed_r2: assert property (@(posedge clk) disable iff (rst)
    ok_pulse |-> $past(state_q == ST_ARMED));
endmodule

// File: rtl/wdk_seq_check.sv
module wdk_seq_check #(
  parameter int    DATA_W   = 16,
  parameter int    GAP_MAX  = 20,
  parameter logic [DATA_W-1:0] REF_KEY1 = 16'hA602,
  parameter logic [DATA_W-1:0] REF_KEY2 = 16'hB480,
  parameter logic [DATA_W-1:0] UNL_KEY1 = 16'h5A3C,
  parameter logic [DATA_W-1:0] UNL_KEY2 = 16'h96E1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        byte_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              blocked,
  input  logic              unlock_sel,
  output logic              ok_pulse,
  output logic              err_pulse
);
  logic              word_vld, order_err, pend;
  logic [DATA_W-1:0] word;
  logic              start, armed, expired;

  wdk_assemble #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .byte_en(byte_en),
    .wr_data(wr_data), .blocked(blocked), .flush(expired),
    .word_vld(word_vld), .word(word), .order_err(order_err), .pend(pend)
  );

  wdk_gap_timer #(.GAP_MAX(GAP_MAX)) u_gap (
    .clk(clk), .rst(rst), .start(start), .run(armed), .expired(expired)
  );

  wdk_judge #(
    .DATA_W(DATA_W), .REF_KEY1(REF_KEY1), .REF_KEY2(REF_KEY2),
    .UNL_KEY1(UNL_KEY1), .UNL_KEY2(UNL_KEY2)
  ) u_jdg (
    .clk(clk), .rst(rst), .unlock_sel(unlock_sel),
    .word_vld(word_vld), .word(word), .order_err(order_err),
    .expired(expired), .start(start), .armed(armed),
    .ok_pulse(ok_pulse), .err_pulse(err_pulse)
  );

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(ok_pulse && err_pulse));
  p_ok_single_r11: assert property (@(posedge clk) disable iff (rst)
    ok_pulse |=> !ok_pulse);
  p_first_byte_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!pend && wr_en && !blocked && byte_en == 2'b10 && !expired) |=> !err_pulse);
  p_blocked_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (blocked && !armed) |=> (!ok_pulse && !err_pulse));
endmodule

// File: tb/wdk_seq_check_bench.sv
module wdk_seq_check_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  byte_en = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic        blocked = 1'b0;
  logic        unlock_sel = 1'b0;
  logic        ok_pulse, err_pulse;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [15:0] K1 = 16'hA602;
  localparam logic [15:0] K2 = 16'hB480;
  localparam logic [15:0] U1 = 16'h5A3C;
  localparam logic [15:0] U2 = 16'h96E1;

  always #4 clk = ~clk;

  wdk_seq_check u_wdk_seq_check (
    .clk(clk), .rst(rst), .wr_en(wr_en), .byte_en(byte_en),
    .wr_data(wr_data), .blocked(blocked), .unlock_sel(unlock_sel),
    .ok_pulse(ok_pulse), .err_pulse(err_pulse)
  );

  task automatic check(input string req, input logic eok, input logic eerr);
    n_chk++;
    if (ok_pulse !== eok || err_pulse !== eerr) begin
      n_fail++;
      $display("FAIL %s: ok/err=%b/%b expected %b/%b at %0t",
               req, ok_pulse, err_pulse, eok, eerr, $time);
    end
  endtask

  // drives one write; returns at the falling edge after it was sampled
  task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic blk);
    wr_en = 1'b1; byte_en = be; wr_data = d; blocked = blk;
    @(negedge clk);
    wr_en = 1'b0; byte_en = 2'b00; blocked = 1'b0;
  endtask

  task automatic gap(input int k);
    repeat (k - 1) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0, 1'b0);
  endtask

  task automatic t_word16;
    wr(2'b11, K1, 1'b0); check("R2 key1 word", 0, 0);
    gap(5);
    wr(2'b11, K2, 1'b0); check("R2 key2 word", 1, 0);
    @(negedge clk);      check("R11 pulse width", 0, 0);
  endtask

  task automatic t_bytes;
    wr(2'b10, {K1[15:8], 8'h00}, 1'b0); check("R3 first byte quiet", 0, 0);
    wr(2'b01, {8'h00, K1[7:0]}, 1'b0);  check("R3 key1 bytes", 0, 0);
    wr(2'b10, {K2[15:8], 8'h00}, 1'b0); check("R3 hi byte quiet", 0, 0);
    wr(2'b01, {8'h00, K2[7:0]}, 1'b0);  check("R3 key2 bytes", 1, 0);
    @(negedge clk);
  endtask

  task automatic t_mixed;
    wr(2'b10, {K1[15:8], 8'h00}, 1'b0);
    wr(2'b01, {8'h00, K1[7:0]}, 1'b0);
    wr(2'b11, K2, 1'b0);                check("R4 bytes then word", 1, 0);
    @(negedge clk);
    wr(2'b11, K1, 1'b0);
    wr(2'b10, {K2[15:8], 8'h00}, 1'b0);
    wr(2'b01, {8'h00, K2[7:0]}, 1'b0);  check("R4 word then bytes", 1, 0);
    @(negedge clk);
  endtask

  task automatic t_gap20;
    wr(2'b11, K1, 1'b0);
    gap(20);
    wr(2'b11, K2, 1'b0); check("R5 gap 20 passes", 1, 0);
    @(negedge clk);
    // byte form: high byte at gap 19, completing low byte at gap 20
    wr(2'b11, K1, 1'b0);
    gap(19);
    wr(2'b10, {K2[15:8], 8'h00}, 1'b0);
    wr(2'b01, {8'h00, K2[7:0]}, 1'b0);  check("R5 byte gap 20 passes", 1, 0);
    @(negedge clk);
  endtask

  task automatic t_gap21;
    wr(2'b11, K1, 1'b0);
    gap(21);
    wr(2'b11, K2, 1'b0); check("R5 gap 21 times out", 0, 1);
    @(negedge clk);      check("R11 err single", 0, 0);
  endtask

  task automatic t_silent;
    wr(2'b11, K1, 1'b0);
    for (int j = 1; j <= 21; j++) begin
      @(negedge clk);
      check("R6 silent timeout", 0, (j == 21));
    end
    @(negedge clk);
  endtask

  task automatic t_wrong;
    wr(2'b11, 16'h1234, 1'b0); check("R7 wrong key1 word", 0, 1);
    @(negedge clk);
    wr(2'b11, K1, 1'b0);
    wr(2'b10, {K2[15:8], 8'h00}, 1'b0); check("R7 hi byte quiet", 0, 0);
    wr(2'b01, 16'h0081, 1'b0);          check("R7 wrong low byte", 0, 1);
    @(negedge clk);
    wr(2'b10, 16'h7700, 1'b0);          check("R3 wrong hi byte quiet", 0, 0);
    wr(2'b01, {8'h00, K1[7:0]}, 1'b0);  check("R7 wrong hi byte", 0, 1);
    @(negedge clk);
    // back in idle: key2 alone is wrong
    wr(2'b11, K2, 1'b0);                check("R7 idle after error", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_order;
    wr(2'b01, {8'h00, K1[7:0]}, 1'b0);  check("R8 low first", 0, 1);
    @(negedge clk);
    wr(2'b10, {K1[15:8], 8'h00}, 1'b0);
    wr(2'b11, K1, 1'b0);                check("R8 word over pending", 0, 1);
    @(negedge clk);
    wr(2'b10, {K1[15:8], 8'h00}, 1'b0);
    wr(2'b10, {K1[15:8], 8'h00}, 1'b0); check("R8 double high", 0, 1);
    @(negedge clk);
    // pending byte was discarded: a lone low byte is now out of order
    wr(2'b01, {8'h00, K1[7:0]}, 1'b0);  check("R8 pending dropped", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_blocked;
    wr(2'b11, K1, 1'b1);  check("R9 blocked key1 quiet", 0, 0);
    wr(2'b11, K2, 1'b0);  check("R9 blocked key1 ignored", 0, 1);
    @(negedge clk);
    wr(2'b11, K1, 1'b0);
    wr(2'b11, 16'hDEAD, 1'b1); check("R9 blocked wrong quiet", 0, 0);
    wr(2'b11, K2, 1'b0);       check("R9 sequence survives", 1, 0);
    @(negedge clk);
  endtask

  task automatic t_unlock;
    unlock_sel = 1'b1;
    @(negedge clk);
    wr(2'b11, U1, 1'b0);
    wr(2'b11, U2, 1'b0); check("R10 unlock keys", 1, 0);
    @(negedge clk);
    wr(2'b11, K1, 1'b0); check("R10 refresh key rejected", 0, 1);
    @(negedge clk);
    unlock_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fresh;
    wr(2'b11, K1, 1'b0);
    wr(2'b11, K2, 1'b0); check("R11 success", 1, 0);
    wr(2'b11, K2, 1'b0); check("R11 fresh key1 needed", 0, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word16();
    t_bytes();
    t_mixed();
    t_gap20();
    t_gap21();
    t_silent();
    t_wrong();
    t_order();
    t_blocked();
    t_unlock();
    t_fresh();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, got no end expected end");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule